// File: doc/BRIEF.md
# Programmable Video Sync Generator

The block derives every raster timing signal from a single pixel clock. A horizontal counter steps through the clocks of one line. A vertical counter steps through the lines of a frame. In interlaced mode it steps through half-lines instead. Each output pulse is a set/clear flop. It turns on when its counter equals a programmed "on" count and turns off when the counter equals a programmed "off" count. A pulse can therefore sit anywhere in the line or frame, and it may wrap across the counter's end.

All counts are 12-bit values that arrive on input ports from a register bank outside the block. The scanning mode is not a separate setting. It follows from the line length: when half the line total is odd, the raster is interlaced, and the vertical counter advances at mid-line as well as at the end of the line.

A window of lines, also programmed, marks the vertical interval. Inside that window the composite sync output carries twice-per-line pulses. These are narrow equalizing pulses, or broad serration pulses while vertical sync is active. Outside the window, composite sync follows the horizontal sync rule. The horizontal and vertical sync outputs remain available as separate gating signals.

Top module: `video_sync_gen`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, all outputs are 0. Both counters restart at 1.
- R2: The horizontal counter runs from 1 up to `h_total`. At the edge where it is at or above `h_total`, it returns to 1. `hsync` goes to 1 one clock after the counter equals `hsync_on` and to 0 one clock after it equals `hsync_off`; otherwise it holds.
- R3: `hblank` follows the same set/clear rule as `hsync`, using `hblank_on` and `hblank_off` against the horizontal counter.
- R4: The vertical counter advances by one when the horizontal counter is at its end. In interlaced mode it also advances when the horizontal counter equals `h_total`/2 (rounded down). Once at or above `v_total`, the next advance returns it to 1.
- R5: Interlaced mode is selected exactly when bit 1 of `h_total` is 1, that is, when `h_total`/2 is odd.
- R6: `vsync` and `vblank` follow the set/clear rule against the vertical counter, evaluated on every clock, using their own on/off pairs.
- R7: `field` toggles at each vertical wrap in interlaced mode and holds its value in non-interlaced mode.
- R8: A vertical window flop follows the set/clear rule on the vertical counter with `eqwin_on`/`eqwin_off`. The half-line position is defined as follows: when the horizontal counter is above `h_total`/2, it is the counter minus `h_total`/2; otherwise it is the counter itself. While the window is open and `vsync` is 0, `csync` sets at half-line position 1 and clears at position `eq_off`.
- R9: While the window is open and `vsync` is 1, `csync` sets at half-line position 1 and clears at position `serr_off`.
- R10: While the window is closed, `csync` follows the `hsync` set/clear rule on the horizontal counter.
- R11: `cblank` equals `hblank` OR `vblank` in every cycle.
- R12: When an on count and an off count match in the same cycle, the pulse goes to 0 (clear wins).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_total | input | 12 | Last horizontal count of a line |
| v_total | input | 12 | Last vertical count of a frame (lines, or half-lines when interlaced) |
| hsync_on | input | 12 | Horizontal count that raises hsync |
| hsync_off | input | 12 | Horizontal count that drops hsync |
| hblank_on | input | 12 | Horizontal count that raises hblank |
| hblank_off | input | 12 | Horizontal count that drops hblank |
| vsync_on | input | 12 | Vertical count that raises vsync |
| vsync_off | input | 12 | Vertical count that drops vsync |
| vblank_on | input | 12 | Vertical count that raises vblank |
| vblank_off | input | 12 | Vertical count that drops vblank |
| eqwin_on | input | 12 | Vertical count that opens the equalizing window |
| eqwin_off | input | 12 | Vertical count that closes the equalizing window |
| eq_off | input | 12 | Half-line position ending an equalizing pulse |
| serr_off | input | 12 | Half-line position ending a serration pulse |
| hsync | output | 1 | Horizontal sync / horizontal gate |
| hblank | output | 1 | Horizontal blanking |
| vsync | output | 1 | Vertical sync / vertical gate |
| vblank | output | 1 | Vertical blanking |
| csync | output | 1 | Composite sync with equalizing and serration pulses |
| cblank | output | 1 | Composite blanking |
| field | output | 1 | Odd/even field flag |

## Verification
Two of the block's functions can fall in the same cycle, and each is provoked deliberately.

The first is a pulse's set and clear. The bench programs `hsync_on` equal to `hsync_off`, `vblank_on` equal to `vblank_off`, and `eq_off` equal to 1. The set and clear compares then hit together, and the outputs are judged to stay low, as R12 requires.

The second is the end-of-line and mid-line vertical steps, which both occur within one line in interlaced mode. Here the vertical pulses are programmed so that their edges land on mid-line steps, and serration and equalizing pulses alternate within the window. The behavioural reference predicts every output on every clock, so any shift by one half-line or one clock shows up as a miscompare.

// File: rtl/video_sync_gen.sv
module video_sync_gen #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] h_total,
  input  logic [W-1:0] v_total,
  input  logic [W-1:0] hsync_on,
  input  logic [W-1:0] hsync_off,
  input  logic [W-1:0] hblank_on,
  input  logic [W-1:0] hblank_off,
  input  logic [W-1:0] vsync_on,
  input  logic [W-1:0] vsync_off,
  input  logic [W-1:0] vblank_on,
  input  logic [W-1:0] vblank_off,
  input  logic [W-1:0] eqwin_on,
  input  logic [W-1:0] eqwin_off,
  input  logic [W-1:0] eq_off,
  input  logic [W-1:0] serr_off,
  output logic         hsync,
  output logic         hblank,
  output logic         vsync,
  output logic         vblank,
  output logic         csync,
  output logic         cblank,
  output logic         field
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] hcnt, vcnt, h_half, hpos;
  logic         ilace, h_end, v_step, v_end, eqwin, cs_nxt;

  function automatic logic pulse(logic cur, logic [W-1:0] c, logic [W-1:0] on, logic [W-1:0] off);
    if (c == off) return 1'b0;
    if (c == on)  return 1'b1;
    return cur;
  endfunction

  assign h_half = h_total >> 1;
  assign ilace  = h_total[1];
  assign h_end  = hcnt >= h_total;
  assign v_step = h_end || (ilace && hcnt == h_half);
  assign v_end  = vcnt >= v_total;
  assign hpos   = (hcnt > h_half) ? hcnt - h_half : hcnt;
  assign cblank = hblank | vblank;

  always_comb begin
    if (!eqwin)     cs_nxt = pulse(csync, hcnt, hsync_on, hsync_off);
    else if (vsync) cs_nxt = pulse(csync, hpos, ONE, serr_off);
    else            cs_nxt = pulse(csync, hpos, ONE, eq_off);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt   <= ONE;
      vcnt   <= ONE;
      hsync  <= 1'b0;
      hblank <= 1'b0;
      vsync  <= 1'b0;
      vblank <= 1'b0;
      eqwin  <= 1'b0;
      csync  <= 1'b0;
      field  <= 1'b0;
    end else begin
      hcnt   <= h_end ? ONE : hcnt + ONE;
      if (v_step) begin
        vcnt <= v_end ? ONE : vcnt + ONE;
        if (v_end && ilace) field <= ~field;
      end
      hsync  <= pulse(hsync, hcnt, hsync_on, hsync_off);
      hblank <= pulse(hblank, hcnt, hblank_on, hblank_off);
      vsync  <= pulse(vsync, vcnt, vsync_on, vsync_off);
      vblank <= pulse(vblank, vcnt, vblank_on, vblank_off);
      eqwin  <= pulse(eqwin, vcnt, eqwin_on, eqwin_off);
      csync  <= cs_nxt;
    end
  end

  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    h_end |=> hcnt == ONE);
  a_r2_hsync_set: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt == hsync_on && hcnt != hsync_off) |=> hsync);
  a_r12_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt == hsync_off) |=> !hsync);
  a_r4_vhold: assert property (@(posedge clk) disable iff (!rst_n)
    !v_step |=> $stable(vcnt));
  a_r6_vblank_off: assert property (@(posedge clk) disable iff (!rst_n)
    (vcnt == vblank_off) |=> !vblank);
  a_r7_field_ilace: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(field) |-> $past(ilace));

endmodule

// File: tb/video_sync_gen_bench.sv
`timescale 1ns/1ps
module video_sync_gen_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] h_total, v_total, hs_on, hs_off, hb_on, hb_off, vs_on, vs_off;
  logic [11:0] vb_on, vb_off, ew_on, ew_off, eq_off, serr_off;
  logic hsync, hblank, vsync, vblank, csync, cblank, field;
  int vectors = 0, errors = 0;
  bit done = 0;
  string phase = "R1 reset";

  always #2 clk = ~clk;

  video_sync_gen u_video_sync_gen (
    .clk(clk), .rst_n(rst_n), .h_total(h_total), .v_total(v_total),
    .hsync_on(hs_on), .hsync_off(hs_off), .hblank_on(hb_on), .hblank_off(hb_off),
    .vsync_on(vs_on), .vsync_off(vs_off), .vblank_on(vb_on), .vblank_off(vb_off),
    .eqwin_on(ew_on), .eqwin_off(ew_off), .eq_off(eq_off), .serr_off(serr_off),
    .hsync(hsync), .hblank(hblank), .vsync(vsync), .vblank(vblank),
    .csync(csync), .cblank(cblank), .field(field));

  // behavioural reference
  int m_h = 1, m_v = 1, m_hs = 0, m_hb = 0, m_vs = 0, m_vb = 0, m_ew = 0, m_cs = 0, m_fd = 0;

  function automatic int setclr(int cur, int c, int on, int off);
    if (c == off) return 0;   // R12 clear wins
    if (c == on) return 1;
    return cur;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_h = 1; m_v = 1; m_hs = 0; m_hb = 0; m_vs = 0; m_vb = 0; m_ew = 0; m_cs = 0; m_fd = 0;
    end else begin
      int half, pos, il, cs, step;
      half = int'(h_total) / 2;
      il   = (half % 2 == 1);                           // R5
      pos  = (m_h > half) ? m_h - half : m_h;
      if (m_ew == 0)      cs = setclr(m_cs, m_h, hs_on, hs_off);   // R10
      else if (m_vs != 0) cs = setclr(m_cs, pos, 1, serr_off);     // R9
      else                cs = setclr(m_cs, pos, 1, eq_off);       // R8
      step = (m_h >= int'(h_total)) || (il && m_h == half);        // R4
      m_hs = setclr(m_hs, m_h, hs_on, hs_off);
      m_hb = setclr(m_hb, m_h, hb_on, hb_off);
      m_vs = setclr(m_vs, m_v, vs_on, vs_off);
      m_vb = setclr(m_vb, m_v, vb_on, vb_off);
      m_ew = setclr(m_ew, m_v, ew_on, ew_off);
      m_cs = cs;
      if (step) begin
        if (m_v >= int'(v_total)) begin
          m_v = 1;
          if (il) m_fd = 1 - m_fd;                                 // R7
        end else m_v = m_v + 1;
      end
      m_h = (m_h >= int'(h_total)) ? 1 : m_h + 1;                  // R2
    end
  end

  task automatic cmp(string req, logic act, int exp);
    if (act !== exp[0]) begin
      errors++;
      $display("FAIL %s [%s] t=%0t actual=%0b expected=%0d", req, phase, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    vectors++;
    cmp("R2 hsync", hsync, m_hs);
    cmp("R3 hblank", hblank, m_hb);
    cmp("R6 vsync (R4 count)", vsync, m_vs);
    cmp("R6 vblank (R4 count)", vblank, m_vb);
    cmp("R8/R9/R10 csync", csync, m_cs);
    cmp("R11 cblank", cblank, (m_hb | m_vb));
    cmp("R7 field", field, m_fd);
  end

  task automatic cfg(int ht, int vt, int a, int b, int c, int d, int e, int f,
                     int g, int h, int i, int j, int k, int l);
    @(negedge clk); #1 rst_n = 1'b0;
    h_total = 12'(ht); v_total = 12'(vt); hs_on = 12'(a); hs_off = 12'(b);
    hb_on = 12'(c); hb_off = 12'(d); vs_on = 12'(e); vs_off = 12'(f);
    vb_on = 12'(g); vb_off = 12'(h); ew_on = 12'(i); ew_off = 12'(j);
    eq_off = 12'(k); serr_off = 12'(l);
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    cfg(20, 10, 3, 6, 1, 8, 3, 5, 1, 4, 2, 7, 3, 8);
    phase = "R1 reset";
    repeat (2) @(negedge clk);
    phase = "non-interlaced R2 R3 R4 R5 R6 R8 R9 R10 R11";
    repeat (650) @(negedge clk);
    // interlaced: 22/2 = 11 odd; hblank wraps across line end; 15 half-lines per frame
    cfg(22, 15, 2, 5, 20, 4, 4, 7, 14, 3, 3, 10, 2, 9);
    phase = "interlaced R4 R5 R7 R8 R9";
    repeat (900) @(negedge clk);
    // coincident set and clear
    cfg(22, 9, 5, 5, 3, 3, 2, 6, 4, 4, 1, 8, 1, 1);
    phase = "collision R12";
    repeat (500) @(negedge clk);
    // mid-run reset
    phase = "R1 reset";
    cfg(26, 11, 3, 9, 24, 2, 5, 8, 10, 2, 4, 9, 2, 10);
    phase = "interlaced after reset R1 R7";
    repeat (900) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule